// File: doc/BRIEF.md
# I2C Open-Drain Port Expander Target

This block is an I2C target that makes eight general-purpose pins reachable over a two-wire bus. It samples SCL and SDA with a fast system clock through short synchronizers. On the synchronized lines it finds START, repeated START and STOP conditions and shifts in the address byte. If the seven upper address bits match the configured address, the block acknowledges. It then either accepts a stream of output bytes that set the pins, or returns live snapshots of the pins.

Each port pin is open-drain. A latched 0 pulls the pin low and a latched 1 lets it float. The block reports this on `pin_drive_low`, where a 1 means "pull low". SDA is driven the same way, through `sda_oe`: when it is 1 the line is pulled low. The bus lines, the pins and the outputs are plain level signals with no handshake. A controller that wants to pause simply holds SCL low, because every action of the target waits for an SCL edge.

Top module: `i2c_port_expander`

## Requirements
- R1: After reset `pin_drive_low` is 8'h00 (all pins released) and `sda_oe` is 0.
- R2: The address byte is taken MSB first on SCL rising edges, and the R/W bit (bit 0) is left out of the comparison. Both 8'h40 (write) and 8'h41 (read) match. On a match, `sda_oe` is 1 from the SCL falling edge after the eighth address bit until the falling edge that ends the ninth clock.
- R3: On an address mismatch, SDA is never pulled low (no ACK) and all further bytes are ignored until the next START. `pin_drive_low` stays unchanged.
- R4: In a write transfer, each data byte is acknowledged and `pin_drive_low` becomes the bitwise inverse of the byte (data bit i at 0 pulls pin i low). Any number of bytes may follow, one after another, until STOP or START.
- R5: In a read transfer, `pin_i` is sampled at the SCL falling edge that ends the preceding ACK slot. The byte is sent MSB first, with `sda_oe` equal to the inverse of the current bit.
- R6: After each sent byte SDA is released for the ninth clock and the controller's bit is sampled on its rising edge. A 0 starts a new byte from a fresh `pin_i` sample. A 1 leaves SDA released until STOP or START.
- R7: A START at any point, even in the middle of a data byte, drops the current transfer and restarts address reception with SDA released. A partly received data byte never reaches the pins.
- R8: A STOP returns the block to idle with SDA released, and `pin_drive_low` keeps its last written value.
- R9: `sda_oe` only changes after an SCL falling edge, or when it is released on START or STOP. It therefore never changes while SCL is high during a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low |
| pin_i | input | 8 | Levels seen on the eight port pins |
| pin_drive_low | output | 8 | Bit i at 1 pulls port pin i low |

## Verification
The hardest case to reach is a repeated START in the middle of a data byte. The bench first gets the target into the write-data phase with a matching address. It then clocks only four data bits and raises SDA while SCL is low. After that it raises SCL and pulls SDA low while SCL stays high. A full write must then succeed, and the pins must show nothing from the abandoned half byte. A bus model that forms the wired-AND of controller and target drive also checks that the target never moves SDA while SCL is high.

// File: rtl/pexp_pkg.sv
package pexp_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_DATA,
    ST_WR_ACK,
    ST_RD_DATA,
    ST_RD_ACK,
    ST_SKIP
  } pexp_state_e;
endpackage

// File: rtl/pexp_sync.sv
module pexp_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/pexp_bus_cond.sv
module pexp_bus_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] lvl;
  logic [LINES-1:0] prev;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    pexp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw[g]),
      .dout (lvl[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= lvl;
  end

  logic scl_hi_held;
  assign scl_hi_held = lvl[1] & prev[1];
  assign sda_lvl     = lvl[0];
  assign scl_rise    = lvl[1] & ~prev[1];
  assign scl_fall    = ~lvl[1] & prev[1];
  assign start_det   = scl_hi_held & prev[0] & ~lvl[0];
  assign stop_det    = scl_hi_held & ~prev[0] & lvl[0];

  p_cond_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_det && stop_det));
endmodule

// File: rtl/pexp_port_latch.sv
module pexp_port_latch
  import pexp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [BYTE_W-1:0] drive_low
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      drive_low <= '0;
    else if (wr_stb) drive_low <= ~wr_byte;
  end

  p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drive_low) |-> $past(wr_stb));
endmodule

// File: rtl/pexp_ctrl.sv
module pexp_ctrl
  import pexp_pkg::*;
#(
  parameter logic [BYTE_W-1:0] DEV_ADDR = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] pin_i,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_byte
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  pexp_state_e       state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] rx_sr;
  logic [BYTE_W-1:0] tx_sr;
  logic              rd_dir;
  logic              ctl_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      rx_sr   <= '0;
      tx_sr   <= '1;
      rd_dir  <= 1'b0;
      ctl_ack <= 1'b0;
      sda_oe  <= 1'b0;
      wr_stb  <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_WR_DATA: begin
            if (scl_rise && cnt < FULL) begin
              rx_sr <= {rx_sr[BYTE_W-2:0], sda_lvl};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              if (state == ST_WR_DATA) begin
                wr_stb <= 1'b1;
                sda_oe <= 1'b1;
                state  <= ST_WR_ACK;
              end else if (rx_sr[BYTE_W-1:1] == DEV_ADDR[BYTE_W-1:1]) begin
                rd_dir <= rx_sr[0];
                sda_oe <= 1'b1;
                state  <= ST_ADDR_ACK;
              end else begin
                state  <= ST_SKIP;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rd_dir) begin
                tx_sr  <= pin_i;
                sda_oe <= ~pin_i[BYTE_W-1];
                state  <= ST_RD_DATA;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WR_DATA;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= ST_WR_DATA;
            end
          end
          ST_RD_DATA: begin
            if (scl_fall) begin
              if (cnt == LAST) begin
                sda_oe <= 1'b0;
                state  <= ST_RD_ACK;
              end else begin
                tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b1};
                sda_oe <= ~tx_sr[BYTE_W-2];
                cnt    <= cnt + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              ctl_ack <= ~sda_lvl;
            end else if (scl_fall) begin
              if (ctl_ack) begin
                tx_sr  <= pin_i;
                sda_oe <= ~pin_i[BYTE_W-1];
                cnt    <= '0;
                state  <= ST_RD_DATA;
              end else begin
                state  <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_byte = rx_sr;

  p_oe_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

  p_quiet_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_SKIP) |-> !sda_oe);

  p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_det) |-> (state == ST_IDLE && !sda_oe));

  p_start_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start_det) && !$past(stop_det)) |-> (state == ST_ADDR && cnt == '0 && !sda_oe));

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

  p_wr_only_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> state == ST_WR_ACK);
endmodule

// File: rtl/i2c_port_expander.sv
module i2c_port_expander
  import pexp_pkg::*;
#(
  parameter logic [BYTE_W-1:0] DEV_ADDR    = 8'h40,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [BYTE_W-1:0] pin_i,
  output logic [BYTE_W-1:0] pin_drive_low
);
  logic              sda_lvl;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              wr_stb;
  logic [BYTE_W-1:0] wr_byte;

  pexp_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  pexp_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .pin_i    (pin_i),
    .sda_oe   (sda_oe),
    .wr_stb   (wr_stb),
    .wr_byte  (wr_byte)
  );

  pexp_port_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (wr_stb),
    .wr_byte  (wr_byte),
    .drive_low(pin_drive_low)
  );
endmodule

// File: tb/i2c_port_expander_tb.sv
module i2c_port_expander_tb;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [7:0] pins = 8'h00;
  logic       sda_oe;
  logic [7:0] drive_low;
  logic       sda_bus;

  int checks = 0;
  int failures = 0;
  int r9_viol = 0;
  logic oe_prev = 1'b0;

  assign sda_bus = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2c_port_expander u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl),
    .sda_i        (sda_bus),
    .sda_oe       (sda_oe),
    .pin_i        (pins),
    .pin_drive_low(drive_low)
  );

  // R9 monitor: the target must never move SDA while the bench holds SCL high
  always @(posedge clk) begin
    if (rst_n && sda_oe != oe_prev && scl) r9_viol++;
    oe_prev <= sda_oe;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_bit(input logic v, output logic seen);
    sda_m = v;   qwait();
    scl = 1'b1;  qwait();
    seen = sda_bus; qwait();
    scl = 1'b0;  qwait();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait();
    scl = 1'b1;   qwait();
    sda_m = 1'b0; qwait();
    scl = 1'b0;   qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl = 1'b1;   qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic write_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic read_byte(input logic nack, input logic [7:0] next_pins, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      b[i] = s;
    end
    pins = next_pins;
    bus_bit(nack, s);
  endtask

  task automatic t_reset();
    check("R1 drive_low after reset", {24'h0, drive_low}, 32'h0);
    check("R1 sda_oe after reset", {31'h0, sda_oe}, 32'h0);
  endtask

  task automatic t_write_burst();
    logic a;
    bus_start();
    write_byte(8'h40, a);
    check("R2 ack for 0x40", {31'h0, a}, 32'h1);
    write_byte(8'h5A, a);
    check("R4 ack data 1", {31'h0, a}, 32'h1);
    check("R4 pins after 0x5A", {24'h0, drive_low}, 32'hA5);
    write_byte(8'h0F, a);
    check("R4 ack data 2", {31'h0, a}, 32'h1);
    check("R4 pins after 0x0F", {24'h0, drive_low}, 32'hF0);
    bus_stop();
    qwait();
    check("R8 sda released after stop", {31'h0, sda_oe}, 32'h0);
    check("R8 latch kept after stop", {24'h0, drive_low}, 32'hF0);
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] b;
    pins = 8'hC3;
    bus_start();
    write_byte(8'h41, a);
    check("R2 ack for 0x41", {31'h0, a}, 32'h1);
    read_byte(1'b0, 8'h3C, b);
    check("R5 first read byte", {24'h0, b}, 32'hC3);
    read_byte(1'b1, 8'h00, b);
    check("R6 resampled byte after ACK", {24'h0, b}, 32'h3C);
    read_byte(1'b1, 8'h00, b);
    check("R6 SDA released after NACK", {24'h0, b}, 32'hFF);
    bus_stop();
    qwait();
  endtask

  task automatic t_mismatch();
    logic a;
    bus_start();
    write_byte(8'h52, a);
    check("R3 no ack on mismatch", {31'h0, a}, 32'h0);
    write_byte(8'h00, a);
    check("R3 no ack on ignored data", {31'h0, a}, 32'h0);
    check("R3 pins unchanged", {24'h0, drive_low}, 32'hF0);
    bus_stop();
    qwait();
  endtask

  task automatic t_restart_mid_byte();
    logic a;
    logic s;
    bus_start();
    write_byte(8'h40, a);
    for (int i = 0; i < 4; i++) bus_bit(1'b0, s);
    bus_start();
    check("R7 partial byte not latched", {24'h0, drive_low}, 32'hF0);
    write_byte(8'h40, a);
    check("R7 ack after restart", {31'h0, a}, 32'h1);
    write_byte(8'h99, a);
    check("R7 write after restart", {24'h0, drive_low}, 32'h66);
    bus_stop();
    qwait();
  endtask

  task automatic run_all();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write_burst();
    t_read();
    t_mismatch();
    t_restart_mid_byte();
    check("R9 no SDA change with SCL high", r9_viol, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule